// File: doc/BRIEF.md
# Shared Multi-Line Receive Silo with Alarm

This block gathers received characters from eight serial line receivers into one shared first-in, first-out store of 64 entries. Each entry records the character, the number of the line it came from, and its framing and parity error flags. The oldest entry is always shown as a 16-bit receive buffer word. A single read strobe takes that entry out of the store.

Each receiver gives a one-cycle ready strobe together with its character and error flags. Strobes that arrive in the same cycle are first caught in small hold registers, one per line. They are then written into the store one per clock, the lowest line number first. If the store is full, the newest character is thrown away. The loss is recorded and reported in the next entry that is stored.

For interrupts, the block offers two conditions: receive-done (the store is not empty) and an alarm mode. The alarm mode waits until sixteen characters have arrived since the last read. The block merges its receive request with an external transmit request. The receive request always wins, and its vector is 4 below the transmit vector.

Top module: `mux_rx_silo`

## Requirements
- R1: Up to DEPTH (64) characters are kept and read back in arrival order, with no loss and no overrun indication while the count stays at or below DEPTH.
- R2: The buffer word is laid out as follows: bit 15 data valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bit 11 zero, bits 10:8 source line, bits 7:0 character.
- R3: `rx_done` is high whenever the store holds at least one entry. A lone strobe makes it visible after two rising clock edges.
- R4: A high `buf_rd` in a cycle removes the entry shown in that cycle. A read of an empty store returns an all-zero word and changes nothing.
- R5: Strobes from several lines in the same cycle are all stored, one per clock, in rising line-number order.
- R6: A character that arrives while the store is full is discarded and `overrun_flag` goes high. The next stored character carries bit 14 set, and storing it clears `overrun_flag`.
- R7: `silo_alarm` goes high once ALARM_LEVEL (16) characters have been stored since the last read or clear. Fifteen are not enough.
- R8: Any read strobe restarts the alarm count, so `silo_alarm` is low in the cycle after a read.
- R9: The receive interrupt condition is `rx_int_en` and (`silo_alarm` when `alarm_en` is set, otherwise `rx_done`). `irq_req` is high when that condition holds or `tx_irq_req` is high.
- R10: When a receive request is pending, `irq_vector` equals VEC_BASE (192), even if a transmit request is also pending. A transmit request alone gives VEC_BASE+4 (196).
- R11: `dev_clear` empties the store and the hold registers, and clears the overrun and alarm state. In the next cycle `rx_done`, `silo_alarm` and `overrun_flag` are low.
- R12: When the store is full and a character is stored in the same cycle as a read, the character is accepted and no overrun is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_clear | input | 1 | Synchronous clear of the store and its flags |
| rx_int_en | input | 1 | Receive interrupt enable |
| alarm_en | input | 1 | Selects alarm mode for the receive interrupt |
| tx_irq_req | input | 1 | Transmit interrupt request from the transmit side |
| line_stb | input | 8 | Per-line character-ready strobe |
| line_data | input | 64 | Per-line character, line n in bits 8n+7:8n |
| line_ferr | input | 8 | Per-line framing error flag |
| line_perr | input | 8 | Per-line parity error flag |
| buf_rd | input | 1 | Read strobe for the buffer word |
| rbuf_word | output | 16 | Oldest entry as a buffer word |
| rx_done | output | 1 | Store not empty |
| silo_alarm | output | 1 | Alarm count reached |
| overrun_flag | output | 1 | A character was lost and has not yet been reported |
| irq_req | output | 1 | Merged interrupt request |
| irq_vector | output | 9 | Vector of the winning request |

## Verification
Two operations can meet in the same cycle: a character being written into the store and a read taking the oldest entry out. This matters most when the store is exactly full. The bench fills the store to 64 entries, raises a line strobe, and then asserts `buf_rd` in the cycle when the held character is written. It then expects no overrun and a 64-entry drain that ends with the new character. The same overlap also restarts the alarm count, and the R8 property checks that restart after every read.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int NUM_LINES = 8;
  localparam int CHAR_W    = 8;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int WORD_W    = CHAR_W + LINE_W + 5;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] data;
  } silo_entry_t;
endpackage

// File: rtl/rx_line_arb.sv
// Per-line hold registers drained one per clock, lowest line first.
module rx_line_arb
  import rx_silo_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [NUM_LINES-1:0]        stb,
  input  logic [NUM_LINES*CHAR_W-1:0] data,
  input  logic [NUM_LINES-1:0]        ferr,
  input  logic [NUM_LINES-1:0]        perr,
  output logic                       push_vld,
  output silo_entry_t                push_ent
);
  logic [NUM_LINES-1:0] hold_vld;
  logic [NUM_LINES-1:0] hold_fe;
  logic [NUM_LINES-1:0] hold_pe;
  logic [CHAR_W-1:0]    hold_chr [NUM_LINES];
  logic [NUM_LINES-1:0] grant;
  logic [LINE_W-1:0]    sel;
  logic                 found;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_hold
    logic              vld_q, vld_d;
    logic              fe_q, fe_d, pe_q, pe_d;
    logic [CHAR_W-1:0] chr_q, chr_d;

    always_comb begin
      vld_d = vld_q;
      fe_d  = fe_q;
      pe_d  = pe_q;
      chr_d = chr_q;
      if (grant[g]) vld_d = 1'b0;
      if (stb[g]) begin
        vld_d = 1'b1;
        chr_d = data[g*CHAR_W +: CHAR_W];
        fe_d  = ferr[g];
        pe_d  = perr[g];
      end
      if (flush) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        fe_q  <= 1'b0;
        pe_q  <= 1'b0;
        chr_q <= '0;
      end else begin
        vld_q <= vld_d;
        if (stb[g]) begin
          fe_q  <= fe_d;
          pe_q  <= pe_d;
          chr_q <= chr_d;
        end
      end
    end

    assign hold_vld[g] = vld_q;
    assign hold_fe[g]  = fe_q;
    assign hold_pe[g]  = pe_q;
    assign hold_chr[g] = chr_q;
  end

  always_comb begin
    grant = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (hold_vld[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        sel      = LINE_W'(i);
      end
    end
  end

  assign push_vld      = found && !flush;
  assign push_ent.ovr  = 1'b0;
  assign push_ent.ferr = hold_fe[sel];
  assign push_ent.perr = hold_pe[sel];
  assign push_ent.line = sel;
  assign push_ent.data = hold_chr[sel];
endmodule

// File: rtl/rx_silo_store.sv
// Circular store with occupancy count and pending-loss marker.
module rx_silo_store
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        push_vld,
  input  silo_entry_t push_ent,
  input  logic        pop_req,
  output silo_entry_t head_ent,
  output logic        not_empty,
  output logic        lost,
  output logic        push_acc
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  silo_entry_t        mem [DEPTH];
  logic [PTR_W-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               lost_q, lost_d;
  logic               pop, full, drop;
  silo_entry_t        wr_ent;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign pop       = pop_req && not_empty && !flush;
  assign push_acc  = push_vld && !flush && (!full || pop);
  assign drop      = push_vld && !flush && !push_acc;

  always_comb begin
    wr_ent     = push_ent;
    wr_ent.ovr = lost_q;
  end

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q + CNT_W'(push_acc) - CNT_W'(pop);
    lost_d = lost_q;
    if (push_acc) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)      rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (drop)          lost_d = 1'b1;
    else if (push_acc) lost_d = 1'b0;
    if (flush) begin
      wr_d   = '0;
      rd_d   = '0;
      cnt_d  = '0;
      lost_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_q] <= wr_ent;
  end

  assign head_ent = mem[rd_q];
  assign lost     = lost_q;
endmodule

// File: rtl/rx_alarm_cnt.sv
// Counts stored characters since the last read; saturates at LEVEL.
module rx_alarm_cnt #(
  parameter int LEVEL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic rd_stb,
  input  logic push_acc,
  output logic alarm
);
  localparam int AW = $clog2(LEVEL + 1);

  logic [AW-1:0] cnt_q, cnt_d, base;

  always_comb begin
    base  = rd_stb ? '0 : cnt_q;
    cnt_d = base;
    if (push_acc && (base < AW'(LEVEL))) cnt_d = base + 1'b1;
    if (flush) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign alarm = (cnt_q == AW'(LEVEL));
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  parameter int VEC_W       = 9,
  parameter int VEC_BASE    = 192
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dev_clear,
  input  logic                        rx_int_en,
  input  logic                        alarm_en,
  input  logic                        tx_irq_req,
  input  logic [NUM_LINES-1:0]        line_stb,
  input  logic [NUM_LINES*CHAR_W-1:0] line_data,
  input  logic [NUM_LINES-1:0]        line_ferr,
  input  logic [NUM_LINES-1:0]        line_perr,
  input  logic                        buf_rd,
  output logic [WORD_W-1:0]           rbuf_word,
  output logic                        rx_done,
  output logic                        silo_alarm,
  output logic                        overrun_flag,
  output logic                        irq_req,
  output logic [VEC_W-1:0]            irq_vector
);
  localparam logic [VEC_W-1:0] RX_VEC = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] TX_VEC = VEC_W'(VEC_BASE + 4);

  logic        push_vld, push_acc, not_empty, lost, alarm;
  silo_entry_t push_ent, head_ent;
  logic        rx_cond, rx_irq;

  rx_line_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (dev_clear),
    .stb      (line_stb),
    .data     (line_data),
    .ferr     (line_ferr),
    .perr     (line_perr),
    .push_vld (push_vld),
    .push_ent (push_ent)
  );

  rx_silo_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (dev_clear),
    .push_vld  (push_vld),
    .push_ent  (push_ent),
    .pop_req   (buf_rd),
    .head_ent  (head_ent),
    .not_empty (not_empty),
    .lost      (lost),
    .push_acc  (push_acc)
  );

  rx_alarm_cnt #(.LEVEL(ALARM_LEVEL)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (dev_clear),
    .rd_stb   (buf_rd),
    .push_acc (push_acc),
    .alarm    (alarm)
  );

  assign rbuf_word = not_empty ?
      {1'b1, head_ent.ovr, head_ent.ferr, head_ent.perr, 1'b0, head_ent.line, head_ent.data} :
      '0;
  assign rx_done      = not_empty;
  assign silo_alarm   = alarm;
  assign overrun_flag = lost;

  always_comb begin
    rx_cond    = alarm_en ? alarm : not_empty;
    rx_irq     = rx_int_en && rx_cond;
    irq_req    = rx_irq || tx_irq_req;
    irq_vector = rx_irq ? RX_VEC : TX_VEC;
  end
endmodule

// File: rtl/mux_rx_silo_chk.sv
module mux_rx_silo_chk #(
  parameter int VEC_W    = 9,
  parameter int VEC_BASE = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_clear,
  input logic             rx_int_en,
  input logic             alarm_en,
  input logic             tx_irq_req,
  input logic             buf_rd,
  input logic             rx_done,
  input logic             silo_alarm,
  input logic             overrun_flag,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vector
);
  // R11
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clear |=> (!rx_done && !silo_alarm && !overrun_flag));

  // R7
  alarm_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    silo_alarm |-> rx_done);

  // R8
  read_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !dev_clear) |=> !silo_alarm);

  // R6
  overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_flag) |-> rx_done);

  // R10
  rx_vector_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_int_en && !alarm_en && rx_done) |-> (irq_req && irq_vector == VEC_W'(VEC_BASE)));

  // R10
  tx_vector_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq_req && !rx_int_en) |-> (irq_req && irq_vector == VEC_W'(VEC_BASE + 4)));

  // R9
  no_request_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_irq_req && !rx_int_en) |-> !irq_req);
endmodule

bind mux_rx_silo mux_rx_silo_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .dev_clear    (dev_clear),
  .rx_int_en    (rx_int_en),
  .alarm_en     (alarm_en),
  .tx_irq_req   (tx_irq_req),
  .buf_rd       (buf_rd),
  .rx_done      (rx_done),
  .silo_alarm   (silo_alarm),
  .overrun_flag (overrun_flag),
  .irq_req      (irq_req),
  .irq_vector   (irq_vector)
);

// File: tb/mux_rx_silo_tb_top.sv
module mux_rx_silo_tb_top;
  localparam int CAP = 64;

  logic        clk;
  logic        rst_n;
  logic        dev_clear;
  logic        rx_int_en;
  logic        alarm_en;
  logic        tx_irq_req;
  logic [7:0]  line_stb;
  logic [63:0] line_data;
  logic [7:0]  line_ferr;
  logic [7:0]  line_perr;
  logic        buf_rd;
  logic [15:0] rbuf_word;
  logic        rx_done;
  logic        silo_alarm;
  logic        overrun_flag;
  logic        irq_req;
  logic [8:0]  irq_vector;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  logic        pend_ovr = 1'b0;
  logic [15:0] mon_exp;

  mux_rx_silo dut_i (
    .clk(clk), .rst_n(rst_n), .dev_clear(dev_clear), .rx_int_en(rx_int_en),
    .alarm_en(alarm_en), .tx_irq_req(tx_irq_req), .line_stb(line_stb),
    .line_data(line_data), .line_ferr(line_ferr), .line_perr(line_perr),
    .buf_rd(buf_rd), .rbuf_word(rbuf_word), .rx_done(rx_done),
    .silo_alarm(silo_alarm), .overrun_flag(overrun_flag), .irq_req(irq_req),
    .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic fe, logic pe, logic [2:0] ln, logic [7:0] d);
    return {1'b1, 1'b0, fe, pe, 1'b0, ln, d};
  endfunction

  // Scoreboard model: capacity CAP, newest dropped, loss marked on next stored.
  task automatic model_push(input logic [15:0] w);
    logic [15:0] x;
    x = w;
    if (exp_q.size() >= CAP) pend_ovr = 1'b1;
    else begin
      x[14] = pend_ovr;
      pend_ovr = 1'b0;
      exp_q.push_back(x);
    end
  endtask

  // Monitor: every read cycle compares the shown word with the model head.
  always @(negedge clk) begin
    if (rst_n && buf_rd) begin
      mon_exp = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0000;
      check(rbuf_word == mon_exp, "R1 R2 R4 read word", 32'(rbuf_word), 32'(mon_exp));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_burst(input int ln, input int n, input logic [7:0] seed, input logic fe, input logic pe);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      d = seed + 8'(i);
      line_stb = '0;
      line_stb[ln] = 1'b1;
      line_data[ln*8 +: 8] = d;
      line_ferr[ln] = fe;
      line_perr[ln] = pe;
      model_push(mk(fe, pe, 3'(ln), d));
    end
    @(posedge clk); #1;
    line_stb = '0;
  endtask

  task automatic drain(input int n);
    @(posedge clk); #1;
    buf_rd = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    buf_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; dev_clear = 1'b0; rx_int_en = 1'b0; alarm_en = 1'b0;
    tx_irq_req = 1'b0; line_stb = '0; line_data = '0; line_ferr = '0;
    line_perr = '0; buf_rd = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // Reset state (R3, R11)
    check(!rx_done && !silo_alarm && !overrun_flag && !irq_req && rbuf_word == 16'h0,
          "R11 reset state", {rx_done, silo_alarm, overrun_flag, irq_req, rbuf_word}, 32'h0);

    // Empty read returns zero and changes nothing (R4)
    drain(1);
    idle(1);
    check(!rx_done, "R4 empty read", 32'(rx_done), 32'h0);

    // Lone strobe: done after two edges (R3) and word layout (R2)
    @(posedge clk); #1;
    line_stb[5] = 1'b1; line_data[47:40] = 8'hA5; line_ferr[5] = 1'b1; line_perr[5] = 1'b0;
    model_push(mk(1'b1, 1'b0, 3'd5, 8'hA5));
    @(posedge clk); #1;
    line_stb = '0;
    check(!rx_done, "R3 not yet done after one edge", 32'(rx_done), 32'h0);
    @(posedge clk); #1;
    check(rx_done, "R3 done after two edges", 32'(rx_done), 32'h1);
    check(rbuf_word == 16'hA5A5, "R2 layout line5 framing", 32'(rbuf_word), 32'hA5A5);
    drain(1);

    // All eight lines in one cycle: stored in line order (R5)
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) begin
      line_data[i*8 +: 8] = 8'h10 + 8'(i);
      line_perr[i] = i[0];
      line_ferr[i] = 1'b0;
      model_push(mk(1'b0, i[0], 3'(i), 8'h10 + 8'(i)));
    end
    line_stb = 8'hFF;
    @(posedge clk); #1;
    line_stb = '0;
    idle(10);
    check(rbuf_word == 16'h8010, "R5 line 0 first", 32'(rbuf_word), 32'h8010);
    drain(8);
    idle(1);
    check(!rx_done, "R5 all eight drained", 32'(rx_done), 32'h0);

    // Alarm mode: 15 no interrupt, 16th raises it (R7, R9, R10)
    alarm_en = 1'b1; rx_int_en = 1'b1;
    send_burst(1, 15, 8'h40, 1'b0, 1'b0);
    idle(3);
    check(!silo_alarm && !irq_req, "R7 fifteen no alarm", {silo_alarm, irq_req}, 32'h0);
    send_burst(1, 1, 8'h7F, 1'b0, 1'b0);
    idle(3);
    check(silo_alarm && irq_req, "R7 sixteenth alarm", {silo_alarm, irq_req}, 32'h3);
    check(irq_vector == 9'd192, "R10 receive vector", 32'(irq_vector), 32'd192);
    drain(1);
    check(!silo_alarm && !irq_req && rx_done, "R8 read rearms alarm",
          {silo_alarm, irq_req, rx_done}, 32'h1);
    drain(15);
    alarm_en = 1'b0;

    // Receive-done interrupt and priority over transmit (R9, R10)
    send_burst(6, 1, 8'h33, 1'b0, 1'b1);
    idle(3);
    check(irq_req && irq_vector == 9'd192, "R9 done interrupt", {irq_req, irq_vector}, {1'b1, 9'd192});
    tx_irq_req = 1'b1;
    #1;
    check(irq_vector == 9'd192, "R10 receive wins tie", 32'(irq_vector), 32'd192);
    rx_int_en = 1'b0;
    #1;
    check(irq_req && irq_vector == 9'd196, "R10 transmit vector", {irq_req, irq_vector}, {1'b1, 9'd196});
    rx_int_en = 1'b1;
    drain(1);
    check(irq_req && irq_vector == 9'd196, "R10 transmit after empty", {irq_req, irq_vector}, {1'b1, 9'd196});
    tx_irq_req = 1'b0; rx_int_en = 1'b0;

    // Fill to exactly full depth (R1)
    send_burst(2, CAP, 8'h00, 1'b0, 1'b0);
    idle(3);
    check(rx_done && !overrun_flag, "R1 full without overrun", {rx_done, overrun_flag}, 32'h2);

    // Store and read in the same cycle at full depth (R12)
    @(posedge clk); #1;
    line_stb[4] = 1'b1; line_data[39:32] = 8'hC3; line_ferr[4] = 1'b0; line_perr[4] = 1'b0;
    @(posedge clk); #1;
    line_stb = '0;
    buf_rd = 1'b1;
    @(posedge clk); #1;
    buf_rd = 1'b0;
    exp_q.push_back(mk(1'b0, 1'b0, 3'd4, 8'hC3));
    idle(2);
    check(!overrun_flag && rx_done, "R12 overlap accepted", {overrun_flag, rx_done}, 32'h1);

    // Two more characters while full are lost (R6)
    send_burst(3, 2, 8'hE0, 1'b1, 1'b1);
    idle(3);
    check(overrun_flag, "R6 overrun flagged", 32'(overrun_flag), 32'h1);
    drain(CAP);
    idle(1);
    check(!rx_done && overrun_flag, "R6 loss kept after drain", {rx_done, overrun_flag}, 32'h1);
    send_burst(7, 1, 8'h5A, 1'b0, 1'b0);
    idle(3);
    check(rbuf_word == 16'hC75A && !overrun_flag, "R6 next entry marked",
          {overrun_flag, rbuf_word}, 32'hC75A);
    drain(1);

    // Device clear empties store and flags (R11)
    send_burst(0, 20, 8'h90, 1'b0, 1'b0);
    send_burst(1, 1, 8'h01, 1'b0, 1'b0);
    @(posedge clk); #1;
    dev_clear = 1'b1;
    @(posedge clk); #1;
    dev_clear = 1'b0;
    exp_q.delete();
    pend_ovr = 1'b0;
    check(!rx_done && !silo_alarm && !overrun_flag && rbuf_word == 16'h0, "R11 clear",
          {rx_done, silo_alarm, overrun_flag, rbuf_word}, 32'h0);
    idle(3);
    check(!rx_done, "R11 holds flushed", 32'(rx_done), 32'h0);
    drain(1);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule